// File: doc/BRIEF.md
# Normalizing Shift-Subtract Unsigned Divider

This block divides one unsigned 32-bit operand by another and returns both the quotient and the remainder. Instead of always running one step per result bit, it first aligns a working copy of the divisor to the dividend by doubling it, one doubling per clock. It then walks that copy back down, one compare-and-subtract step per clock. It stops as soon as the halved working copy drops below the original divisor, so small quotients finish in a few cycles.

A caller holds the operands steady, pulses `start_i` while the block is idle, and waits for the one-cycle `done_o` pulse. The results stay on `quotient_o` and `remainder_o` until the next operation changes them. The static input `rem_only_i` turns off every update of the quotient register, which leaves only the remainder to be computed. A zero divisor is caught when the operation is accepted and answered at once with an error flag.

The states are IDLE, ALIGN and SUB.
- IDLE --start, divisor zero--> IDLE: the error result is written and done is raised.
- IDLE --start, divisor nonzero--> ALIGN: the operands are loaded.
- ALIGN --working divisor <= remainder>>1--> ALIGN: the working divisor is doubled.
- ALIGN --otherwise--> SUB: the quotient is cleared.
- SUB --halved working divisor >= divisor--> SUB: one subtract step is taken.
- SUB --halved working divisor < divisor--> IDLE: the last subtract step is taken and done is raised.

Top module: `norm_divider`

## Requirements
- R1: After reset, busy_o, done_o and div_zero_o are 0, and quotient_o and remainder_o are 0.
- R2: For a nonzero divisor b and a dividend a, when done_o is 1, quotient_o equals floor(a/b) and remainder_o equals a mod b, and div_zero_o is 0.
- R3: Let k be the number of times w can be doubled, starting from w = b, while w <= (a >> 1). Then done_o rises exactly 2k+2 clock edges after the edge that samples start_i.
- R4: When the dividend is below the divisor, the result is quotient 0 and remainder equal to the dividend, with done_o rising 2 edges after the start edge.
- R5: While rem_only_i is 1, the remainder is still correct, and quotient_o keeps the value it had before the operation started.
- R6: done_o is high for one cycle only, unless a zero-divisor start is accepted in that cycle. busy_o is 0 whenever done_o is 1.
- R7: A start_i pulse that arrives while busy_o is 1 is ignored. The running operation finishes with the operands it was started with.
- R8: A zero divisor makes done_o and div_zero_o 1 in the cycle after the start edge, with quotient_o all ones, remainder_o equal to the dividend, and busy_o staying 0.
- R9: The full operand range is handled without overflow. For example, 0xFFFFFFFF / 1 gives quotient 0xFFFFFFFF and remainder 0 after 31 doublings (latency 64).
- R10: A start_i pulse in the same cycle as done_o is accepted, and it begins the next operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation when idle |
| dividend_i | input | 32 | Unsigned dividend |
| divisor_i | input | 32 | Unsigned divisor |
| rem_only_i | input | 1 | Static: 1 suppresses all quotient updates |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| div_zero_o | output | 1 | Completion was a zero-divisor error |
| quotient_o | output | 32 | Quotient result |
| remainder_o | output | 32 | Remainder result |

## Verification
Completion and acceptance of a new operation can fall in the same cycle: in the cycle where done_o is high the controller is already idle, so a start_i raised there is taken at once. The bench raises start_i at exactly the point where it sees done_o. It then checks two things: the first result is still present during the done cycle, and the second operation returns its own quotient and remainder after its own computed latency. A separate case pulses start_i in the middle of a busy operation and requires the first operation's result to come back unchanged.

// File: rtl/ndiv_pkg.sv
package ndiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_SUB   = 2'd2
    } ndiv_state_e;

    // Datapath operation issued each cycle by the controller
    typedef enum logic [2:0] {
        OP_HOLD   = 3'd0,
        OP_LOAD   = 3'd1,
        OP_ZERO   = 3'd2,
        OP_DOUBLE = 3'd3,
        OP_ENTER  = 3'd4,
        OP_STEP   = 3'd5
    } ndiv_op_e;

endpackage

// File: rtl/ndiv_ctrl.sv
module ndiv_ctrl
    import ndiv_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_i,
    input  logic     zero_i,
    input  logic     fits_i,
    input  logic     last_i,
    output ndiv_op_e op_o,
    output logic     busy_o,
    output logic     done_o,
    output logic     err_o
);

    ndiv_state_e state_q, state_d;
    logic        done_d, err_d;

    always_comb begin
        state_d = state_q;
        op_o    = OP_HOLD;
        done_d  = 1'b0;
        err_d   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (zero_i) begin
                        op_o   = OP_ZERO;
                        done_d = 1'b1;
                        err_d  = 1'b1;
                    end else begin
                        op_o    = OP_LOAD;
                        state_d = ST_ALIGN;
                    end
                end
            end
            ST_ALIGN: begin
                if (fits_i) begin
                    op_o = OP_DOUBLE;
                end else begin
                    op_o    = OP_ENTER;
                    state_d = ST_SUB;
                end
            end
            ST_SUB: begin
                op_o = OP_STEP;
                if (last_i) begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            done_o <= done_d;
            err_o  <= err_d;
        end
    end

    assign busy_o = (state_q != ST_IDLE);

    // R6: completion is never reported while an operation is still running
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R8: an error completion comes only together with a done pulse
    a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);

endmodule

// File: rtl/ndiv_datapath.sv
module ndiv_datapath
    import ndiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  ndiv_op_e     op_i,
    input  logic         rem_only_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o,
    output logic         zero_o,
    output logic         fits_o,
    output logic         last_o
);

    localparam int WX = W + 1;

    logic [W-1:0]  rem_q, quo_q, orig_q;
    logic [WX-1:0] wdiv_q;
    logic          ge;

    assign ge     = {1'b0, rem_q} >= wdiv_q;
    assign zero_o = (divisor_i == '0);
    assign fits_o = wdiv_q <= {2'b00, rem_q[W-1:1]};
    assign last_o = (wdiv_q >> 1) < {1'b0, orig_q};
    assign quo_o  = quo_q;
    assign rem_o  = rem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            orig_q <= '0;
            wdiv_q <= '0;
        end else begin
            unique case (op_i)
                OP_LOAD: begin
                    rem_q  <= dividend_i;
                    orig_q <= divisor_i;
                    wdiv_q <= {1'b0, divisor_i};
                end
                OP_ZERO: begin
                    rem_q <= dividend_i;
                    quo_q <= '1;
                end
                OP_DOUBLE: wdiv_q <= wdiv_q << 1;
                OP_ENTER: begin
                    if (!rem_only_i) quo_q <= '0;
                end
                OP_STEP: begin
                    if (ge) rem_q <= rem_q - wdiv_q[W-1:0];
                    if (!rem_only_i) quo_q <= {quo_q[W-2:0], ge};
                    wdiv_q <= wdiv_q >> 1;
                end
                default: ;
            endcase
        end
    end

    // R2: a subtract step never grows the running remainder
    a_r2_rem_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_STEP) |=> (rem_q <= $past(rem_q)));

    // R9: while subtracting, the working divisor stays at or above the divisor
    a_r9_wdiv_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_STEP) |-> (wdiv_q >= {1'b0, orig_q}));

    // R9: doubling never reaches the extra top bit
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_DOUBLE) |=> !wdiv_q[W]);

endmodule

// File: rtl/norm_divider.sv
module norm_divider
    import ndiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    input  logic         rem_only_i,
    output logic         busy_o,
    output logic         done_o,
    output logic         div_zero_o,
    output logic [W-1:0] quotient_o,
    output logic [W-1:0] remainder_o
);

    ndiv_op_e op;
    logic     zero, fits, last;

    ndiv_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .zero_i  (zero),
        .fits_i  (fits),
        .last_i  (last),
        .op_o    (op),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .err_o   (div_zero_o)
    );

    ndiv_datapath #(.W(W)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_i       (op),
        .rem_only_i (rem_only_i),
        .dividend_i (dividend_i),
        .divisor_i  (divisor_i),
        .quo_o      (quotient_o),
        .rem_o      (remainder_o),
        .zero_o     (zero),
        .fits_o     (fits),
        .last_o     (last)
    );

    // R6: a done pulse lasts one cycle unless a zero-divisor start follows
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o || div_zero_o));

    // R8: the error result carries an all-ones quotient
    a_r8_err_quotient: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero_o |-> (quotient_o == '1));

    // R5: in remainder-only mode a running operation leaves the quotient alone
    a_r5_quotient_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (rem_only_i && busy_o) |=> $stable(quotient_o));

    // R7: a start seen while busy never produces an error completion
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> !div_zero_o);

endmodule

// File: tb/norm_divider_tb.sv
module norm_divider_tb;

    localparam int W = 32;
    localparam int NV = 8;

    // each vector: dividend, divisor, expected quotient, expected remainder
    localparam logic [4*W-1:0] VEC [NV] = '{
        {32'd100,        32'd7,          32'd14,         32'd2},
        {32'hFFFF_FFFF,  32'd1,          32'hFFFF_FFFF,  32'd0},
        {32'hFFFF_FFFF,  32'hFFFF_FFFF,  32'd1,          32'd0},
        {32'd5,          32'd9,          32'd0,          32'd5},
        {32'h8000_0000,  32'd3,          32'h2AAA_AAAA,  32'd2},
        {32'd1000000,    32'd1000,       32'd1000,       32'd0},
        {32'd0,          32'd5,          32'd0,          32'd0},
        {32'd12345678,   32'h0001_0000,  32'd188,        32'd24910}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [W-1:0] dividend_i = '0;
    logic [W-1:0] divisor_i = '0;
    logic         rem_only_i = 1'b0;
    logic         busy_o, done_o, div_zero_o;
    logic [W-1:0] quotient_o, remainder_o;

    int checks = 0;
    int errors = 0;
    int lat;

    always #10 clk = ~clk;

    norm_divider #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .dividend_i(dividend_i), .divisor_i(divisor_i), .rem_only_i(rem_only_i),
        .busy_o(busy_o), .done_o(done_o), .div_zero_o(div_zero_o),
        .quotient_o(quotient_o), .remainder_o(remainder_o)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic int doublings(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] w;
        int n;
        w = {1'b0, b};
        n = 0;
        while (w <= {2'b00, a[W-1:1]}) begin
            w = w << 1;
            n++;
        end
        return n;
    endfunction

    // Called just after a falling edge; returns at the falling edge where done_o is seen
    task automatic run(input logic [W-1:0] a, input logic [W-1:0] b);
        dividend_i = a;
        divisor_i  = b;
        start_i    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        while (!done_o && lat < 200) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", {31'd0, busy_o}, 32'd0);
        check("R1 done", {31'd0, done_o}, 32'd0);
        check("R1 err", {31'd0, div_zero_o}, 32'd0);
        check("R1 quotient", quotient_o, 32'd0);
        check("R1 remainder", remainder_o, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R9 vector table
        for (int i = 0; i < NV; i++) begin
            logic [W-1:0] a, b, q, r;
            {a, b, q, r} = VEC[i];
            run(a, b);
            check("R2 quotient", quotient_o, q);
            check("R2 remainder", remainder_o, r);
            check("R2 err low", {31'd0, div_zero_o}, 32'd0);
            check("R3 latency", lat, 2 * doublings(a, b) + 2);
            if (a < b) check("R4 latency", lat, 32'd2);
            if (b == 32'd1) check("R9 latency", lat, 32'd64);
            @(negedge clk);
            check("R6 done dropped", {31'd0, done_o}, 32'd0);
        end

        // R8 zero divisor
        run(32'd77, 32'd0);
        check("R8 latency", lat, 32'd0);
        check("R8 err", {31'd0, div_zero_o}, 32'd1);
        check("R8 quotient", quotient_o, 32'hFFFF_FFFF);
        check("R8 remainder", remainder_o, 32'd77);
        check("R8 not busy", {31'd0, busy_o}, 32'd0);
        @(negedge clk);
        check("R6 err dropped", {30'd0, done_o, div_zero_o}, 32'd0);

        // R5 remainder only keeps prior quotient
        run(32'd100, 32'd7);
        rem_only_i = 1'b1;
        @(negedge clk);
        run(32'd50, 32'd6);
        check("R5 remainder", remainder_o, 32'd2);
        check("R5 quotient kept", quotient_o, 32'd14);
        rem_only_i = 1'b0;
        @(negedge clk);

        // R7 start during busy ignored
        dividend_i = 32'd1000;
        divisor_i  = 32'd3;
        start_i    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        dividend_i = 32'd7;
        divisor_i  = 32'd0;
        start_i    = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        dividend_i = 32'd1000;
        divisor_i  = 32'd3;
        for (int n = 0; n < 200 && !done_o; n++) @(negedge clk);
        check("R7 quotient", quotient_o, 32'd333);
        check("R7 remainder", remainder_o, 32'd1);
        check("R7 err", {31'd0, div_zero_o}, 32'd0);
        @(negedge clk);

        // R10 start in the done cycle
        run(32'd90, 32'd9);
        check("R10 first quotient", quotient_o, 32'd10);
        run(32'd10, 32'd3);
        check("R10 second quotient", quotient_o, 32'd3);
        check("R10 second remainder", remainder_o, 32'd1);
        check("R10 latency", lat, 32'd4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule